// File: doc/BRIEF.md
# Chip-Select Address Decoder

This block sits between an internal bus and an external memory bus and decides which of six external chip-select lines an access belongs to. Every select owns a 16-bit base value and a 16-bit don't-care mask that are compared against the upper half of the 32-bit access address. Each select also has a valid flag and a write-protect flag. These settings live in a small register bank that software reaches through a plain word-wide read/write port.

For each presented access the block returns, one clock later, a one-hot select vector, the index of the winning select, and an error flag. The error flag is raised when a write lands in a protected range. In that case no select is driven, so no external cycle can start. Until select zero is marked valid, select zero claims every access and the other selects stay silent. This lets a boot device be reached before any configuration exists.

Top module: `csd_decoder`

## Requirements
- R1: Select n owns three 32-bit registers at byte offsets 12n (base), 12n+4 (mask) and 12n+8 (control). The base register stores bits 31:16 and reads zero in bits 15:0. The mask register stores the mask in bits 31:16, write protect in bit 8 and valid in bit 0, and reads zero elsewhere. The control register reads back exactly what was written.
- R2: After reset every base, mask and control register reads 0x00000000, and all three result outputs are zero.
- R3: A select's address compare passes when every bit of access address 31:16 equals the stored base bit, except the bits whose mask bit is 1.
- R4: A select numbered 1 or above can win only when its own valid bit and select zero's valid bit are both 1.
- R5: While select zero's valid bit is 0, every access selects select zero whatever its address. Once that bit is 1, select zero obeys its own compare.
- R6: When several selects qualify, the lowest-numbered one wins. The select output has at most one bit set and its index appears on the index output.
- R7: A write whose winning select has write protect set raises the error flag, drives an all-zero select vector and reports the winner's index. Protect bits of selects that lose do not matter.
- R8: A read that hits a protected range asserts its select normally and never raises the error flag.
- R9: An access that no select claims gives an all-zero select vector, index 0 and no error.
- R10: Results are registered and appear in the cycle after the access is presented. A cycle with no access yields all-zero outputs in the next cycle.
- R11: A register write takes effect for accesses from the following cycle on. An access presented in the same cycle as the write is decoded with the old settings.
- R12: Writes to offsets that are not one of the 18 register offsets change no register, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register port strobe |
| reg_we | input | 1 | Register port write (1) or read (0) |
| reg_off | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle as the strobe |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 32 | Access address |
| cs_hit | output | 6 | One-hot winning select, registered |
| cs_idx | output | 3 | Index of the winning select, registered |
| bus_err | output | 1 | Protected-write error, registered |

## Verification
A register write and an access decode can fall in the same cycle. The decode must then use the settings from before the write. The bench provokes this by arming write protect on select four and then, in a single cycle, clearing that protect while presenting a write into select four's range. It expects the error for that access and a clean hit for the identical access in the next cycle. The lowest-index priority is exercised by addresses that overlap in selects one, two and five, where one of the losers is protected.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int CMP_LSB     = 16;
    localparam int CMP_W       = ADDR_W - CMP_LSB;
    localparam int REG_BYTES   = DATA_W / 8;
    localparam int REGS_PER_CS = 3;
    localparam int CS_STRIDE   = REG_BYTES * REGS_PER_CS;
    localparam int VALID_BIT   = 0;
    localparam int WPROT_BIT   = 8;

    typedef enum logic [1:0] {
        SLOT_BASE = 2'd0,
        SLOT_MASK = 2'd1,
        SLOT_CTRL = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic             wprot;
        logic             valid;
    } cs_cfg_t;
endpackage

// File: rtl/csd_regbank.sv
module csd_regbank
    import csd_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int OFF_W  = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_en,
    input  logic                   reg_we,
    input  logic [OFF_W-1:0]       reg_off,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output cs_cfg_t [NUM_CS-1:0]   cfg_o
);
    localparam int BANK_BYTES = NUM_CS * CS_STRIDE;

    typedef struct packed {
        cs_cfg_t [NUM_CS-1:0]            cfg;
        logic [NUM_CS-1:0][DATA_W-1:0]   ctrl;
    } bank_t;

    bank_t             bank_d, bank_q;
    logic [NUM_CS-1:0] ch_sel;
    slot_e             slot;

    // offset decode: one select and one slot, or nothing
    always_comb begin
        ch_sel = '0;
        slot   = SLOT_NONE;
        for (int i = 0; i < NUM_CS; i++) begin
            for (int k = 0; k < REGS_PER_CS; k++) begin
                if (reg_off == OFF_W'(i * CS_STRIDE + k * REG_BYTES)) begin
                    ch_sel[i] = 1'b1;
                    slot      = slot_e'(k[1:0]);
                end
            end
        end
    end

    always_comb begin
        bank_d = bank_q;
        if (reg_en && reg_we) begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (ch_sel[i]) begin
                    case (slot)
                        SLOT_BASE: bank_d.cfg[i].base = reg_wdata[DATA_W-1:CMP_LSB];
                        SLOT_MASK: begin
                            bank_d.cfg[i].mask  = reg_wdata[DATA_W-1:CMP_LSB];
                            bank_d.cfg[i].wprot = reg_wdata[WPROT_BIT];
                            bank_d.cfg[i].valid = reg_wdata[VALID_BIT];
                        end
                        SLOT_CTRL: bank_d.ctrl[i] = reg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_en) begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (ch_sel[i]) begin
                    case (slot)
                        SLOT_BASE: reg_rdata[DATA_W-1:CMP_LSB] = bank_q.cfg[i].base;
                        SLOT_MASK: begin
                            reg_rdata[DATA_W-1:CMP_LSB] = bank_q.cfg[i].mask;
                            reg_rdata[WPROT_BIT]        = bank_q.cfg[i].wprot;
                            reg_rdata[VALID_BIT]        = bank_q.cfg[i].valid;
                        end
                        SLOT_CTRL: reg_rdata = bank_q.ctrl[i];
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cfg_o = bank_q.cfg;

    // R12
    oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && (int'(reg_off) >= BANK_BYTES)) |=> $stable(cfg_o));

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int NUM_CS = 6
) (
    input  cs_cfg_t [NUM_CS-1:0] cfg_i,
    input  logic [CMP_W-1:0]     addr_hi_i,
    output logic [NUM_CS-1:0]    hit_o,
    output logic [NUM_CS-1:0]    prot_o
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
        logic [CMP_W-1:0] care_diff;
        logic             addr_ok;

        assign care_diff = (addr_hi_i ^ cfg_i[g].base) & ~cfg_i[g].mask;
        assign addr_ok   = (care_diff == '0);
        assign prot_o[g] = cfg_i[g].wprot;

        if (g == 0) begin : g_global
            // unconfigured select zero claims everything
            assign hit_o[g] = ~cfg_i[0].valid | addr_ok;
        end else begin : g_plain
            assign hit_o[g] = cfg_i[0].valid & cfg_i[g].valid & addr_ok;
        end
    end
endmodule

// File: rtl/csd_pick.sv
module csd_pick #(
    parameter int NUM_CS = 6,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [NUM_CS-1:0] raw_hit,
    input  logic [NUM_CS-1:0] prot,
    output logic [NUM_CS-1:0] hit_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              err_o
);
    typedef struct packed {
        logic [NUM_CS-1:0] hit;
        logic [IDX_W-1:0]  idx;
        logic              err;
    } res_t;

    res_t              res_d, res_q;
    logic [NUM_CS-1:0] win;
    logic [IDX_W-1:0]  win_idx;
    logic              found;

    // lowest index wins
    always_comb begin
        win     = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (raw_hit[i] && !found) begin
                win[i]  = 1'b1;
                win_idx = IDX_W'(i);
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        res_d = '0;
        if (acc_valid && found) begin
            res_d.idx = win_idx;
            if (acc_write && |(win & prot)) res_d.err = 1'b1;
            else                            res_d.hit = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit_o = res_q.hit;
    assign idx_o = res_q.idx;
    assign err_o = res_q.err;

    // R6
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));

    // R7
    err_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (hit_o == '0));

    // R8
    read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !err_o);

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && raw_hit == '0) |=> (hit_o == '0 && !err_o && idx_o == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (hit_o == '0 && !err_o && idx_o == '0));

endmodule

// File: rtl/csd_decoder.sv
module csd_decoder
    import csd_pkg::*;
#(
    parameter  int NUM_CS = 6,
    localparam int OFF_W  = $clog2(NUM_CS * CS_STRIDE),
    localparam int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NUM_CS-1:0] cs_hit,
    output logic [IDX_W-1:0]  cs_idx,
    output logic              bus_err
);
    cs_cfg_t [NUM_CS-1:0] cfg;
    logic [NUM_CS-1:0]    raw_hit;
    logic [NUM_CS-1:0]    prot;
    logic                 unused_addr_lo;

    // low address bits never take part in the decode
    assign unused_addr_lo = ^acc_addr[CMP_LSB-1:0];

    csd_regbank #(.NUM_CS(NUM_CS), .OFF_W(OFF_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg)
    );

    csd_match #(.NUM_CS(NUM_CS)) u_match (
        .cfg_i     (cfg),
        .addr_hi_i (acc_addr[ADDR_W-1:CMP_LSB]),
        .hit_o     (raw_hit),
        .prot_o    (prot)
    );

    csd_pick #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .raw_hit   (raw_hit),
        .prot      (prot),
        .hit_o     (cs_hit),
        .idx_o     (cs_idx),
        .err_o     (bus_err)
    );

    // R5
    global_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !cfg[0].valid) |=> (cs_hit == NUM_CS'(1) && cs_idx == '0));

    // R4
    gated_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !cfg[0].valid) |=> (cs_hit[NUM_CS-1:1] == '0));

endmodule

// File: tb/csd_decoder_tb.sv
`timescale 1ns/1ps
module csd_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [5:0]  cs_hit;
    logic [2:0]  cs_idx;
    logic        bus_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    csd_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .cs_hit(cs_hit), .cs_idx(cs_idx), .bus_err(bus_err)
    );

    // {addr, write, expected hit, expected idx, expected err}
    localparam int NV = 14;
    localparam logic [42:0] VEC [NV] = '{
        {32'h1000_0000, 1'b0, 6'b000001, 3'd0, 1'b0},  // R3 exact base
        {32'h1000_FFFC, 1'b1, 6'b000001, 3'd0, 1'b0},  // R3 low bits ignored
        {32'h1001_0000, 1'b0, 6'b000000, 3'd0, 1'b0},  // R9 miss
        {32'h2000_0010, 1'b0, 6'b000010, 3'd1, 1'b0},  // R6 ch1 over ch2
        {32'h20AB_0000, 1'b1, 6'b000010, 3'd1, 1'b0},  // R7 loser protect ignored
        {32'h2100_0000, 1'b0, 6'b000100, 3'd2, 1'b0},  // R8 read protected
        {32'h2100_0000, 1'b1, 6'b000000, 3'd2, 1'b1},  // R7 protected write
        {32'h3000_0000, 1'b0, 6'b000000, 3'd0, 1'b0},  // R4 invalid select
        {32'h4003_0000, 1'b0, 6'b010000, 3'd4, 1'b0},  // R8
        {32'h4003_0000, 1'b1, 6'b000000, 3'd4, 1'b1},  // R7
        {32'h4010_0000, 1'b0, 6'b000000, 3'd0, 1'b0},  // R3 cared bit differs
        {32'h7705_1234, 1'b0, 6'b100000, 3'd5, 1'b0},  // R3 high mask
        {32'h2005_0000, 1'b1, 6'b000010, 3'd1, 1'b0},  // R6 three-way overlap
        {32'hFFFF_FFFF, 1'b1, 6'b000000, 3'd0, 1'b0}   // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [6:0] off, input logic [31:0] data);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_off = off; reg_wdata = data;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [6:0] off, output logic [31:0] data);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_off = off;
        #1;
        data = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic access(input logic [31:0] addr, input logic wr,
                          output logic [5:0] h, output logic [2:0] ix, output logic e);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr;
        @(posedge clk);
        #1;
        h = cs_hit; ix = cs_idx; e = bus_err;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic expect_access(input string req, input logic [31:0] addr, input logic wr,
                                 input logic [5:0] eh, input logic [2:0] ei, input logic ee);
        logic [5:0] h;
        logic [2:0] ix;
        logic       e;
        access(addr, wr, h, ix, e);
        check(req, {22'd0, h, ix, e}, {22'd0, eh, ei, ee});
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: all registers and outputs clear
        for (int o = 0; o < 72; o += 4) begin
            reg_read(7'(o), rd);
            check("R2 register reset", rd, 32'h0);
        end
        check("R2 outputs reset", {22'd0, cs_hit, cs_idx, bus_err}, 32'h0);

        // R5: global select before configuration
        expect_access("R5 global read", 32'hDEAD_0000, 1'b0, 6'b000001, 3'd0, 1'b0);
        expect_access("R5 global write", 32'h5555_0000, 1'b1, 6'b000001, 3'd0, 1'b0);

        // R4: valid select one still blocked while select zero is unconfigured
        reg_write(7'd12, 32'h2000_0000);
        reg_write(7'd16, 32'h00FF_0001);
        expect_access("R4 blocked by select zero", 32'h2000_0010, 1'b0, 6'b000001, 3'd0, 1'b0);

        // R10: idle cycle after an access
        @(posedge clk);
        #1;
        check("R10 idle outputs", {22'd0, cs_hit, cs_idx, bus_err}, 32'h0);

        // R1: field storage and readback
        reg_write(7'd24, 32'h2000_ABCD);
        reg_read(7'd24, rd);
        check("R1 base readback", rd, 32'h2000_0000);
        reg_write(7'd28, 32'hFFFF_FFFF);
        reg_read(7'd28, rd);
        check("R1 mask readback", rd, 32'hFFFF_0101);
        reg_write(7'd68, 32'h1234_5678);
        reg_read(7'd68, rd);
        check("R1 control readback", rd, 32'h1234_5678);

        // configuration for the vector table
        reg_write(7'd28, 32'h0FFF_0101);
        reg_write(7'd36, 32'h3000_0000);
        reg_write(7'd40, 32'h0000_0000);
        reg_write(7'd48, 32'h4000_0000);
        reg_write(7'd52, 32'h000F_0101);
        reg_write(7'd60, 32'h0005_0000);
        reg_write(7'd64, 32'hFF00_0001);
        reg_write(7'd0,  32'h1000_0000);
        reg_write(7'd4,  32'h0000_0001);

        // R12: stray offsets
        reg_write(7'd72, 32'hFFFF_FFFF);
        reg_write(7'd2,  32'hFFFF_FFFF);
        reg_read(7'd72, rd);
        check("R12 out-of-range read", rd, 32'h0);
        reg_read(7'd0, rd);
        check("R12 base untouched", rd, 32'h1000_0000);
        reg_read(7'd4, rd);
        check("R12 mask untouched", rd, 32'h0000_0001);

        for (int i = 0; i < NV; i++) begin
            expect_access("R3 R6 R7 R8 R9 vector", VEC[i][42:11], VEC[i][10],
                          VEC[i][9:4], VEC[i][3:1], VEC[i][0]);
        end

        // R11: register write and access in the same cycle
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_off = 7'd52; reg_wdata = 32'h000F_0001;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h4003_0000;
        @(posedge clk);
        #1;
        check("R11 old settings used", {22'd0, cs_hit, cs_idx, bus_err},
              {22'd0, 6'b000000, 3'd4, 1'b1});
        reg_en = 1'b0; reg_we = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
        expect_access("R11 new settings next", 32'h4003_0000, 1'b1, 6'b010000, 3'd4, 1'b0);

        // R5: select zero now follows its own compare
        expect_access("R5 after valid", 32'hDEAD_0000, 1'b0, 6'b000000, 3'd0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule